// File: doc/BRIEF.md
# Grouped priority round-robin DMA channel arbiter

This block decides which of several DMA channels owns the transfer engine. Each channel has an enable input, a two-bit urgency level, a flag that allows it to be displaced, and a trigger input. A trigger on an enabled channel makes that channel pending. Among the pending channels, the arbiter first picks the most urgent urgency level that has any pending channel. It then applies round robin among the pending channels at that level, and each level keeps its own rotation pointer.

The transfer engine is not part of this block. It reports back through two strobes. The first marks the end of one single transfer of the active channel. The second, which is raised together with the first, marks the end of the channel's whole job. The grant changes only when the engine is idle or at a single-transfer boundary. At such a boundary, a displaceable active channel may give way to a pending channel of strictly higher urgency, and a disabled or finished active channel is released. The grant appears as a one-hot vector together with a valid flag.

Top module: `dmaarb_top`

## Requirements
- R1: After reset, act_valid is 0 and act_oh is all zeros.
- R2: A trigger on an enabled channel, sampled at a clock edge, makes the channel pending at that edge. An idle arbiter grants a pending channel at the next edge, so the grant appears two edges after the trigger is presented.
- R3: The urgency level of channel i is ch_prio[2i+1:2i], and 0 is the most urgent value. A grant always goes to a channel of the most urgent level that has a pending channel.
- R4: Within one urgency level, the search starts at that level's pointer and wraps upward. Every pointer is 0 after reset, so the lowest index wins first. On each grant, the pointer of the granted level moves to the granted index plus one.
- R5: act_oh is one-hot or all zeros, and act_valid is 1 exactly when act_oh is not zero. While a channel is active and xfer_done is low, act_oh does not change.
- R6: When xfer_done is high and blk_done is low, an enabled active channel with ch_preempt high is replaced by the winner among the other pending channels, but only if that winner's level is strictly more urgent. With ch_preempt low the channel is kept. A displaced channel stays pending and is granted again later.
- R7: A pending channel at the same level as a displaceable active channel never replaces it at a single-transfer boundary.
- R8: The trigger of a disabled channel is ignored. Disabling a pending channel clears its pending state, so it is not granted after it is enabled again unless it is triggered again.
- R9: An active channel whose enable drops stays active until the next xfer_done. At that edge it is released, and it is not granted again at the same edge.
- R10: When xfer_done and blk_done are high together, the active channel's pending state is cleared. The arbiter grants the next winner at the same edge, or goes idle if no channel is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NCH | Per-channel enable |
| ch_prio | input | NCH*2 | Per-channel urgency level, 2 bits per channel, 0 most urgent |
| ch_preempt | input | NCH | Per-channel flag allowing the channel to be displaced |
| ch_trig | input | NCH | Per-channel trigger |
| xfer_done | input | 1 | The active channel finished one single transfer |
| blk_done | input | 1 | The active channel finished its whole job (valid only with xfer_done) |
| act_oh | output | NCH | One-hot active channel |
| act_valid | output | 1 | A channel is active |

## Verification
The assertions take for granted that xfer_done and blk_done are raised only while a channel is active, and that blk_done is never high without xfer_done. They also assume that urgency levels and displaceable flags do not change while the affected channels are pending or active. The stimulus keeps to this. It raises the engine strobes only after it has seen a grant, it pulses each strobe for exactly one cycle, and it sets urgency levels and flags right after a reset, before any trigger.

// File: rtl/dmaarb_pkg.sv
`timescale 1ns/1ps
package dmaarb_pkg;
  localparam int PRIO_W = 2;
  localparam int NGRP   = 1 << PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_GRANT = 2'd1,
    DEC_IDLE  = 2'd2
  } dec_e;

  // a is strictly more urgent than b (0 is the most urgent)
  function automatic logic more_urgent(prio_t a, prio_t b);
    return a < b;
  endfunction
endpackage

// File: rtl/dmaarb_pend.sv
`timescale 1ns/1ps
module dmaarb_pend #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] trig,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | (trig & en)) & en & ~clr;
  end

  assign pend = pend_q;

  AST_DISABLED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(en)) == '0)); // R8

  AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((pend_q & $past(clr)) == '0)); // R10
endmodule

// File: rtl/dmaarb_rr_grp.sv
`timescale 1ns/1ps
module dmaarb_rr_grp #(
  parameter int NCH = 8,
  parameter int IW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] req,
  input  logic          adv,
  input  logic [IW-1:0] adv_idx,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] ptr_q;

  function automatic logic [IW:0] rr_scan(logic [NCH-1:0] m, logic [IW-1:0] start);
    logic [IW:0] res;
    int j;
    res = '0;
    for (int k = 0; k < NCH; k++) begin
      j = int'(start) + k;
      if (j >= NCH) j = j - NCH;
      if (!res[IW] && m[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  function automatic logic [IW-1:0] next_ptr(logic [IW-1:0] g);
    return (int'(g) == NCH - 1) ? '0 : g + 1'b1;
  endfunction

  logic [IW:0] scan;
  assign scan  = rr_scan(req, ptr_q);
  assign found = scan[IW];
  assign idx   = scan[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= next_ptr(adv_idx);
  end

  AST_RR_PICKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[idx]); // R4
endmodule

// File: rtl/dmaarb_top.sv
`timescale 1ns/1ps
module dmaarb_top
  import dmaarb_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH*PRIO_W-1:0] ch_prio,
  input  logic [NCH-1:0]        ch_preempt,
  input  logic [NCH-1:0]        ch_trig,
  input  logic                  xfer_done,
  input  logic                  blk_done,
  output logic [NCH-1:0]        act_oh,
  output logic                  act_valid
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0] act_q;
  logic           act_v_q;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] cand;
  logic [NCH-1:0] fin_clr;
  logic [IW-1:0]  act_idx;
  prio_t          act_prio;

  // named events for the assertions
  logic boundary_ev, leave_ev, preempt_ev, grant_ev;

  logic [NCH-1:0]  gmask [NGRP];
  logic [NGRP-1:0] grp_found;
  logic [IW-1:0]   grp_idx [NGRP];
  logic            any_win;
  prio_t           win_grp;
  logic [IW-1:0]   win_idx;
  dec_e            dec;

  assign fin_clr = act_q & {NCH{act_v_q & xfer_done & blk_done}};

  dmaarb_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .en(ch_en), .trig(ch_trig), .clr(fin_clr), .pend(pend)
  );

  // the active channel is never a candidate for a second grant
  assign cand = pend & ch_en & ~act_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      for (int i = 0; i < NCH; i++)
        gmask[g][i] = cand[i] && (ch_prio[i*PRIO_W +: PRIO_W] == prio_t'(g));
    end
    dmaarb_rr_grp #(.NCH(NCH), .IW(IW)) u_rr (
      .clk(clk), .rst_n(rst_n), .req(gmask[g]),
      .adv(grant_ev && (win_grp == prio_t'(g))), .adv_idx(win_idx),
      .found(grp_found[g]), .idx(grp_idx[g])
    );
  end

  always_comb begin
    any_win = 1'b0;
    win_grp = '0;
    win_idx = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_found[g]) begin
        any_win = 1'b1;
        win_grp = prio_t'(g);
        win_idx = grp_idx[g];
      end
    end
  end

  always_comb begin
    act_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (act_q[i]) act_idx = IW'(i);
  end
  assign act_prio = ch_prio[act_idx*PRIO_W +: PRIO_W];

  assign boundary_ev = !act_v_q || xfer_done;
  assign leave_ev    = act_v_q && xfer_done && (blk_done || !ch_en[act_idx]);
  assign preempt_ev  = act_v_q && xfer_done && !leave_ev && ch_preempt[act_idx]
                       && any_win && more_urgent(win_grp, act_prio);

  always_comb begin
    dec = DEC_HOLD;
    if (!act_v_q) begin
      if (any_win) dec = DEC_GRANT;
    end else if (leave_ev) begin
      dec = any_win ? DEC_GRANT : DEC_IDLE;
    end else if (preempt_ev) begin
      dec = DEC_GRANT;
    end
  end
  assign grant_ev = (dec == DEC_GRANT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= '0;
      act_v_q <= 1'b0;
    end else begin
      case (dec)
        DEC_GRANT: begin act_q <= NCH'(1) << win_idx; act_v_q <= 1'b1; end
        DEC_IDLE:  begin act_q <= '0;                 act_v_q <= 1'b0; end
        default:   ;
      endcase
    end
  end

  assign act_oh    = act_q;
  assign act_valid = act_v_q;

  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_q) && (act_v_q == (act_q != '0))); // R5

  AST_HOLD_MID_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    act_v_q && !xfer_done |=> $stable(act_q) && act_v_q); // R5

  AST_GRANT_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!act_v_q || act_q == $past(act_q) || (act_q & $past(pend)) != '0)); // R2

  AST_NONPREEMPT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    act_v_q && xfer_done && !blk_done && ch_en[act_idx] && !ch_preempt[act_idx]
    |=> $stable(act_q)); // R6

  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    act_v_q && xfer_done && !ch_en[act_idx] |=> (act_q & $past(act_q)) == '0); // R9

  AST_NO_LEVEL_CHANGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_ev |=> $stable(act_v_q)); // R5
endmodule

// File: tb/dmaarb_top_bench.sv
`timescale 1ns/1ps
module dmaarb_top_bench;
  localparam int NCH = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  ch_en, ch_preempt, ch_trig;
  logic [2*NCH-1:0] ch_prio;
  logic            xfer_done, blk_done;
  logic [NCH-1:0]  act_oh;
  logic            act_valid;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dmaarb_top #(.NCH(NCH)) u_dmaarb_top (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_prio(ch_prio),
    .ch_preempt(ch_preempt), .ch_trig(ch_trig), .xfer_done(xfer_done),
    .blk_done(blk_done), .act_oh(act_oh), .act_valid(act_valid)
  );

  // {prio[15:0], trig[7:0], expected act_oh[7:0]}
  localparam logic [31:0] VEC [6] = '{
    {16'hFFFF, 8'h24, 8'h04},  // same level: lowest index
    {16'hF7FF, 8'h24, 8'h20},  // ch5 at level 1 beats ch2 at level 3
    {16'h0000, 8'hF0, 8'h10},  // all level 0: lowest triggered
    {16'hBFFF, 8'h81, 8'h80},  // ch7 level 2 beats ch0 level 3
    {16'hBFFE, 8'h81, 8'h01},  // both level 2: lower index
    {16'h5555, 8'h00, 8'h00}   // nothing triggered: idle
  };

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [NCH:0] got, logic [NCH:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ch_en = '1; ch_preempt = '0; ch_trig = '0;
    ch_prio = '1; xfer_done = 1'b0; blk_done = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic set_p(int ch, int v);
    ch_prio[ch*2 +: 2] = 2'(v);
  endtask

  task automatic trig(logic [NCH-1:0] m);
    ch_trig = m; cyc(1); ch_trig = '0;
  endtask

  task automatic done(logic blk);
    xfer_done = 1'b1; blk_done = blk; cyc(1);
    xfer_done = 1'b0; blk_done = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 reset idle", {act_valid, act_oh}, '0);

    for (int v = 0; v < 6; v++) begin
      do_reset();
      ch_prio = VEC[v][31:16];
      trig(VEC[v][15:8]);
      cyc(1);
      chk($sformatf("R3 vector %0d", v), {act_valid, act_oh},
          {(VEC[v][7:0] != 8'h00), VEC[v][7:0]});
    end

    // R2: latency of two edges
    do_reset();
    ch_trig = 8'h08; cyc(1); ch_trig = '0;
    chk("R2 not yet granted", {act_valid, act_oh}, '0);
    cyc(1);
    chk("R2 granted", {act_valid, act_oh}, {1'b1, 8'h08});

    // R4: round robin with per-level pointer
    do_reset();
    set_p(1, 1); set_p(3, 1); set_p(5, 1);
    trig(8'h2A); cyc(1);
    chk("R4 first ch1", {act_valid, act_oh}, {1'b1, 8'h02});
    done(1'b1);
    chk("R4 then ch3 (R10)", {act_valid, act_oh}, {1'b1, 8'h08});
    trig(8'h02);
    done(1'b1);
    chk("R4 pointer past ch3 picks ch5", {act_valid, act_oh}, {1'b1, 8'h20});
    done(1'b1);
    chk("R4 then ch1", {act_valid, act_oh}, {1'b1, 8'h02});
    done(1'b1);
    chk("R10 idle when none pending", {act_valid, act_oh}, '0);

    // R5 / R6: preemption at boundary only, displaced channel resumes
    do_reset();
    set_p(0, 0); ch_preempt[2] = 1'b1;
    trig(8'h04); cyc(1);
    chk("R6 ch2 active", {act_valid, act_oh}, {1'b1, 8'h04});
    trig(8'h01); cyc(2);
    chk("R5 held without boundary", {act_valid, act_oh}, {1'b1, 8'h04});
    done(1'b0);
    chk("R6 preempted by ch0", {act_valid, act_oh}, {1'b1, 8'h01});
    done(1'b1);
    chk("R6 ch2 resumes", {act_valid, act_oh}, {1'b1, 8'h04});

    // R6: not displaceable
    do_reset();
    set_p(0, 0);
    trig(8'h04); cyc(1);
    trig(8'h01); cyc(1);
    done(1'b0);
    chk("R6 non-preemptable kept", {act_valid, act_oh}, {1'b1, 8'h04});

    // R7: same level never preempts
    do_reset();
    ch_preempt[2] = 1'b1;
    trig(8'h04); cyc(1);
    trig(8'h10); cyc(1);
    done(1'b0);
    chk("R7 same level kept", {act_valid, act_oh}, {1'b1, 8'h04});
    done(1'b1);
    chk("R10 next in level", {act_valid, act_oh}, {1'b1, 8'h10});

    // R8: disabled trigger ignored, disabling clears pending
    do_reset();
    ch_en[3] = 1'b0;
    trig(8'h08); cyc(2);
    chk("R8 disabled trigger ignored", {act_valid, act_oh}, '0);
    ch_en = '1;
    trig(8'h02); cyc(1);
    trig(8'h40);
    ch_en[6] = 1'b0; cyc(1); ch_en[6] = 1'b1; cyc(1);
    done(1'b1);
    cyc(1);
    chk("R8 cleared pending not granted", {act_valid, act_oh}, '0);

    // R9: disabling the active channel
    do_reset();
    trig(8'h10); cyc(1);
    ch_en[4] = 1'b0; cyc(2);
    chk("R9 kept until boundary", {act_valid, act_oh}, {1'b1, 8'h10});
    done(1'b0);
    chk("R9 released at boundary", {act_valid, act_oh}, '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule